// File: doc/BRIEF.md
# Dual-line audio to I2S serializer

This block takes stereo audio that arrives on two serial data lines, one per channel. Both lines are shifted in together by a shared input bit clock. A word clock frames each sample pair, and the samples are right-justified against its falling edge. The block recovers the left and right words and sends them out again as one interleaved stream in standard I2S or left-justified format. The output runs at twice the input bit rate, so a common audio transmitter or recorder can take the output directly.

All input strobes are asynchronous to the block. A two-flop synchronizer brings them into a fast system clock, and edge detectors follow it. The block makes its output bit clock and channel-select clock by dividing the system clock. One holding register and one transmit register form a two-entry buffer between the input side and the output side. Each output frame is 64 bit clocks long. A newly latched pair starts going out at the first frame start after it arrives. If no new pair has come in, the previous pair is sent again and a sticky underrun flag is raised.

Top module: `dls_i2s_top`

## Requirements
- R1: While rst_ni is low, bclk_o, sdata_o and underrun_o are low, and lrck_o is at the left-channel level of the selected format.
- R2: Both input lines are sampled on each rising edge of bck_i, as seen after synchronization, and are shifted MSB first.
- R3: Only the last 18 bits shifted in before a falling edge of wck_i form the sample. Any earlier bits in the word period have no effect on the output.
- R4: A falling edge of wck_i latches both 18-bit words as one pair. When the input and output rates match, every pair appears exactly once on the output, in order.
- R5: bclk_o has a period of 2*HALF_DIV system clocks, and each channel half lasts 32 bclk_o periods. lrck_o and sdata_o change only on falling edges of bclk_o.
- R6: With fmt_i = 0 (I2S), lrck_o low carries the left channel, and the MSB comes one bclk_o period after the lrck_o edge.
- R7: With fmt_i = 1 (left-justified), lrck_o high carries the left channel, and the MSB is aligned with the lrck_o edge.
- R8: In each 32-bit half, every bit position outside the 18 data bits is sent as zero.
- R9: A new pair is loaded only at the start of a frame, which is the start of the left half. If no pair has arrived since the last load, the previous pair is sent again.
- R10: underrun_o is set at a frame start that finds no new pair, once the first pair has been loaded. It stays set until reset and is never set before the first pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 1 | Output format: 0 = I2S, 1 = left-justified |
| bck_i | input | 1 | Input bit clock |
| wck_i | input | 1 | Input word clock; its falling edge ends a sample pair |
| din_l_i | input | 1 | Left-channel serial data |
| din_r_i | input | 1 | Right-channel serial data |
| bclk_o | output | 1 | Output bit clock |
| lrck_o | output | 1 | Output channel-select clock |
| sdata_o | output | 1 | Interleaved output serial data |
| underrun_o | output | 1 | Sticky flag: a frame started with no new pair |

## Verification
The hardest state to reach from the ports is a frame start that finds the buffer empty after traffic has begun. Reaching it also shows the repeat and the sticky flag. The bench first streams pairs at a rate exactly matched to the output, so one pair lands between every two frame starts and nothing may repeat. It then stops the word clock for several frames, and afterwards resumes the stream to confirm that the sequence continues in order. Every word period also carries junk bits ahead of the valid 18 bits. The bench decodes the serial output at each rising edge of bclk_o under both formats and compares it with walking-bit and extreme-value patterns.

// File: rtl/dls_pkg.sv
package dls_pkg;
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } fmt_e;
endpackage

// File: rtl/dls_sync.sv
module dls_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dls_deser.sv
module dls_deser #(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bck_s_i,
  input  logic              wck_s_i,
  input  logic              dl_s_i,
  input  logic              dr_s_i,
  output logic              pair_valid_o,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o
);
  logic              bck_d, wck_d;
  logic              bit_stb, word_stb;
  logic [WORD_W-1:0] sh_l, sh_r;

  assign bit_stb  = bck_s_i & ~bck_d;
  assign word_stb = ~wck_s_i & wck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bck_d        <= 1'b0;
      wck_d        <= 1'b0;
      sh_l         <= '0;
      sh_r         <= '0;
      left_o       <= '0;
      right_o      <= '0;
      pair_valid_o <= 1'b0;
    end else begin
      bck_d        <= bck_s_i;
      wck_d        <= wck_s_i;
      pair_valid_o <= word_stb;
      // older bits fall off the top: only the last WORD_W survive
      if (bit_stb) begin
        sh_l <= {sh_l[WORD_W-2:0], dl_s_i};
        sh_r <= {sh_r[WORD_W-2:0], dr_s_i};
      end
      if (word_stb) begin
        left_o  <= sh_l;
        right_o <= sh_r;
      end
    end
  end

  // one word clock edge yields exactly one latch pulse
  assert_single_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |=> !pair_valid_o);
endmodule

// File: rtl/dls_tx.sv
module dls_tx
  import dls_pkg::*;
#(
  parameter int WORD_W   = 18,
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              pair_valid_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              bclk_o,
  output logic              lrck_o,
  output logic              sdata_o,
  output logic              underrun_o
);
  localparam int FRAME_W = 2 * SLOT_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int DIV_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);

  fmt_e              fmt;
  logic [DIV_W-1:0]  div_cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [WORD_W-1:0] act_l, act_r;
  logic              pend, primed;
  logic              in_right;
  logic [WORD_W-1:0] word_sel, word_sh;
  int                pos, k;

  assign fmt = fmt_e'(fmt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt    <= '0;
      bclk_o     <= 1'b0;
      bit_idx    <= '0;
      act_l      <= '0;
      act_r      <= '0;
      pend       <= 1'b0;
      primed     <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      if (pair_valid_i) pend <= 1'b1;
      if (div_cnt == DIV_END) begin
        div_cnt <= '0;
        bclk_o  <= ~bclk_o;
        if (bclk_o) begin  // falling edge of bclk_o: advance slot
          if (bit_idx == LAST_IDX) begin
            bit_idx <= '0;
            if (pend || pair_valid_i) begin
              act_l  <= left_i;
              act_r  <= right_i;
              pend   <= 1'b0;
              primed <= 1'b1;
            end else if (primed) begin
              underrun_o <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    in_right = (int'(bit_idx) >= SLOT_W);
    pos      = in_right ? int'(bit_idx) - SLOT_W : int'(bit_idx);
    k        = pos - ((fmt == FMT_I2S) ? 1 : 0);
    word_sel = in_right ? act_r : act_l;
    word_sh  = '0;
    sdata_o  = 1'b0;
    if (k >= 0 && k < WORD_W) begin
      word_sh = word_sel << k;
      sdata_o = word_sh[WORD_W-1];
    end
    lrck_o = (fmt == FMT_I2S) ? in_right : ~in_right;
  end

  assert_slot_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |-> bit_idx == (($past(bit_idx) == LAST_IDX) ? '0 : $past(bit_idx) + 1'b1));

  assert_lrck_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(lrck_o) && $stable(fmt_i)) |-> $fell(bclk_o));

  assert_sdata_on_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdata_o) && $stable(fmt_i)) |-> $fell(bclk_o));

  assert_underrun_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(underrun_o));

  assert_no_underrun_unprimed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |-> !underrun_o);
endmodule

// File: rtl/dls_i2s_top.sv
module dls_i2s_top #(
  parameter int WORD_W      = 18,
  parameter int SLOT_W      = 32,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fmt_i,
  input  logic bck_i,
  input  logic wck_i,
  input  logic din_l_i,
  input  logic din_r_i,
  output logic bclk_o,
  output logic lrck_o,
  output logic sdata_o,
  output logic underrun_o
);
  localparam int N_IN = 4;

  logic [N_IN-1:0]   in_s;
  logic              pair_valid;
  logic [WORD_W-1:0] hold_l, hold_r;

  dls_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({din_r_i, din_l_i, wck_i, bck_i}),
    .q_o    (in_s)
  );

  dls_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bck_s_i      (in_s[0]),
    .wck_s_i      (in_s[1]),
    .dl_s_i       (in_s[2]),
    .dr_s_i       (in_s[3]),
    .pair_valid_o (pair_valid),
    .left_o       (hold_l),
    .right_o      (hold_r)
  );

  dls_tx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .HALF_DIV(HALF_DIV)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fmt_i        (fmt_i),
    .pair_valid_i (pair_valid),
    .left_i       (hold_l),
    .right_i      (hold_r),
    .bclk_o       (bclk_o),
    .lrck_o       (lrck_o),
    .sdata_o      (sdata_o),
    .underrun_o   (underrun_o)
  );
endmodule

// File: tb/dls_i2s_top_tb.sv
module dls_i2s_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 18;
  localparam int SLOT_W     = 32;
  localparam int HALF_DIV   = 2;
  localparam int IN_HALF    = 4;   // sys cycles per input bck phase
  localparam int IN_BITS    = 32;  // bck periods per word clock period
  localparam logic [WORD_W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt = 1'b0;
  logic bck = 1'b0, wck = 1'b0, dl = 1'b0, dr = 1'b0;
  logic bclk_o, lrck_o, sdata_o, underrun_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [WORD_W-1:0] sent_l [64];
  logic [WORD_W-1:0] sent_r [64];
  int n_sent = 0;
  int exp_idx = 0;
  int repeats = 0;

  // decoder state
  logic hbits [SLOT_W];
  int   cnt = 0;
  logic cur_lr = 1'b0;
  bit   have_lr = 1'b0;
  bit   have_l = 1'b0;
  logic [WORD_W-1:0] got_l = '0;
  logic prev_bclk = 1'b0;
  int   cyc = 0;
  int   last_rise = 0;
  bit   have_rise = 1'b0;
  int   period_checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dls_i2s_top #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .HALF_DIV(HALF_DIV)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .fmt_i      (fmt),
    .bck_i      (bck),
    .wck_i      (wck),
    .din_l_i    (dl),
    .din_r_i    (dr),
    .bclk_o     (bclk_o),
    .lrck_o     (lrck_o),
    .sdata_o    (sdata_o),
    .underrun_o (underrun_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_half(input logic lr);
    bit is_left;
    int off;
    logic [WORD_W-1:0] w;
    bit pad_ok;
    is_left = fmt ? (lr == 1'b1) : (lr == 1'b0);
    off = fmt ? 0 : 1;
    w = '0;
    pad_ok = 1'b1;
    for (int i = 0; i < SLOT_W; i++) begin
      if (i >= off && i < off + WORD_W) w = {w[WORD_W-2:0], hbits[i]};
      else if (hbits[i] !== 1'b0) pad_ok = 1'b0;
    end
    chk(pad_ok, "R8 pad bits zero", pad_ok, 1);
    if (is_left) begin
      got_l = w;
      have_l = 1'b1;
    end else if (have_l) begin
      have_l = 1'b0;
      if (exp_idx < n_sent && got_l == sent_l[exp_idx] && w == sent_r[exp_idx]) begin
        chk(1'b1, "R2 R3 R4 R6 R7 frame", 0, 0);
        exp_idx++;
      end else if (exp_idx > 0 && got_l == sent_l[exp_idx-1] && w == sent_r[exp_idx-1]) begin
        repeats++;
      end else if (!(exp_idx == 0 && got_l == '0 && w == '0)) begin
        chk(1'b0, "R2 R3 R4 R6 R7 frame content",
            {got_l, w}, (exp_idx < n_sent) ? {sent_l[exp_idx], sent_r[exp_idx]} : 0);
      end
    end
  endtask

  // output monitor: samples away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      have_lr = 1'b0;
      have_l = 1'b0;
      cnt = 0;
      prev_bclk = 1'b0;
      have_rise = 1'b0;
      period_checks = 0;
    end else begin
      cyc++;
      if (bclk_o && !prev_bclk) begin
        if (have_rise && period_checks < 6) begin
          chk(cyc - last_rise == 2 * HALF_DIV, "R5 bclk period", cyc - last_rise, 2 * HALF_DIV);
          period_checks++;
        end
        last_rise = cyc;
        have_rise = 1'b1;
        if (!have_lr || lrck_o != cur_lr) begin
          if (have_lr) begin
            chk(cnt == SLOT_W, "R5 half length", cnt, SLOT_W);
            if (cnt == SLOT_W) finish_half(cur_lr);
          end
          cur_lr = lrck_o;
          have_lr = 1'b1;
          cnt = 0;
        end
        if (cnt < SLOT_W) hbits[cnt] = sdata_o;
        cnt++;
      end
      prev_bclk = bclk_o;
    end
  end

  task automatic do_reset(input logic f);
    rst_n = 1'b0;
    fmt = f;
    bck = 1'b0; wck = 1'b0; dl = 1'b0; dr = 1'b0;
    n_sent = 0; exp_idx = 0; repeats = 0;
    repeat (4) @(negedge clk);
    chk(bclk_o == 1'b0, "R1 bclk_o in reset", bclk_o, 0);
    chk(sdata_o == 1'b0, "R1 sdata_o in reset", sdata_o, 0);
    chk(underrun_o == 1'b0, "R1 underrun_o in reset", underrun_o, 0);
    chk(lrck_o == f, "R1 R6 R7 lrck_o left level in reset", lrck_o, f);
    rst_n = 1'b1;
  endtask

  task automatic send_pair(input logic [WORD_W-1:0] l, input logic [WORD_W-1:0] r);
    sent_l[n_sent] = l;
    sent_r[n_sent] = r;
    n_sent++;
    for (int b = 0; b < IN_BITS; b++) begin
      if (b == 1) wck = 1'b1;
      if (b < IN_BITS - WORD_W) begin
        dl = 1'($urandom % 2);  // R3: junk ahead of the valid word
        dr = 1'($urandom % 2);
      end else begin
        dl = l[WORD_W-1-(b-(IN_BITS-WORD_W))];
        dr = r[WORD_W-1-(b-(IN_BITS-WORD_W))];
      end
      bck = 1'b0;
      repeat (IN_HALF) @(negedge clk);
      bck = 1'b1;
      repeat (IN_HALF) @(negedge clk);
    end
    bck = 1'b0;
    wck = 1'b0;
  endtask

  task automatic run_phase(input logic f);
    do_reset(f);
    for (int i = 0; i < WORD_W; i++) begin
      if (f) send_pair(~(WORD_W'(1) << i) & MASK, WORD_W'(1) << (WORD_W-1-i));
      else   send_pair(WORD_W'(1) << i, ~(WORD_W'(1) << i) & MASK);
    end
    send_pair(MASK, '0);
    send_pair('0, MASK);
    send_pair(WORD_W'(1) << (WORD_W-1), WORD_W'(1));
    repeat (5) @(negedge clk);
    chk(underrun_o == 1'b0, "R10 no underrun at matched rate", underrun_o, 0);
    chk(repeats == 0, "R4 R9 no repeat at matched rate", repeats, 0);
    repeat (900) @(negedge clk);
    chk(exp_idx == n_sent, "R4 all pairs sent in order", exp_idx, n_sent);
    chk(underrun_o == 1'b1, "R10 underrun after stall", underrun_o, 1);
    chk(repeats >= 1, "R9 previous pair repeated", repeats, 1);
    send_pair(18'h2aaaa, 18'h15555);
    send_pair(18'h00ff0, 18'h3f00f);
    repeat (900) @(negedge clk);
    chk(exp_idx == n_sent, "R4 R9 resume after stall", exp_idx, n_sent);
    chk(underrun_o == 1'b1, "R10 underrun sticky", underrun_o, 1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    run_phase(1'b0);  // I2S
    run_phase(1'b1);  // left-justified
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule